// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vector Output

This block gathers interrupt requests for a small processor core and picks at most one of them each time the core reaches an instruction boundary. Requests come from two places. The first is a set of peripheral status flags, each optionally gated by an enable bit and mapped to an interrupt number. The second is a mask of sources raised directly, such as the software trap, the illegal-opcode trap and the non-maskable line. Requests are held in a pending mask until they are granted or the block is reset.

When the core pulses its boundary strobe, the arbiter resolves the pending mask against the core's two condition-code mask bits. The general mask gates the ordinary sources. The non-maskable mask gates the non-maskable line. The block then registers a one-cycle grant that carries the interrupt number, its vector address, which mask bit the core must set, and the fixed service-entry cycle cost. Among ordinary sources, the winner is chosen by a writable priority-order table. Stacking registers and fetching the vector are left to the core.

Top module: `irq_vector_arb`

## Requirements
- R1: A peripheral flag whose position is marked in FLAG_HAS_EN makes its mapped interrupt pending only while its enable input is also 1. A flag not so marked makes its interrupt pending on the flag alone. With the default map, flags 0 to 3 map to interrupt 1, flag 4 to 2, flag 5 (which has no enable) to 3, flag 6 to 4 and flag 7 to 5. A pending bit stays set after the flag drops.
- R2: The software trap (number 13) wins over everything, and the illegal-opcode trap (number 14) comes next. Both are granted whatever the values of ccr_i and ccr_x.
- R3: The non-maskable source (number 15) is granted only when ccr_x is 0. While it is pending with ccr_x at 1, no grant is made on that boundary, unless one of the two traps is pending. It is granted on a later boundary once ccr_x is 0.
- R4: While ccr_i is 1, no ordinary source (any number other than 13, 14 or 15) is granted. Such sources stay pending and are granted later.
- R5: Ordinary sources are ranked by an order table in which slot 0 has the highest rank. Reset loads slot k with number k, so the lowest pending number wins. A write with ord_we puts ord_id in slot ord_slot, and reset restores the identity order.
- R6: gnt_vec equals 0xFFC0 plus twice gnt_id.
- R7: A grant of number 15 raises gnt_set_x. Any other grant raises gnt_set_i. Exactly one of the two is high with each grant, and neither is high without one.
- R8: Each grant reports gnt_cost equal to 14.
- R9: The granted source's pending bit is cleared on its grant, and other pending bits are kept. Reset clears the whole pending mask.
- R10: raise_cnt is 0 after reset and grows by the number of bits set in sw_raise in each cycle. It is unchanged in cycles where sw_raise is zero.
- R11: Arbitration happens only in a cycle with insn_done high. The grant is registered and appears in the following cycle for one cycle. gnt_vld stays low when nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_in | input | FLAG_N | Peripheral status flags |
| flag_en | input | FLAG_N | Enable bit paired with each flag |
| sw_raise | input | NUM_INT | Direct raise mask, one bit per interrupt number |
| ccr_i | input | 1 | General interrupt mask bit of the core |
| ccr_x | input | 1 | Non-maskable line mask bit of the core |
| insn_done | input | 1 | Instruction-boundary strobe |
| ord_we | input | 1 | Order table write enable |
| ord_slot | input | ID_W | Order table slot to write |
| ord_id | input | ID_W | Interrupt number stored in that slot |
| gnt_vld | output | 1 | Grant valid, one cycle |
| gnt_id | output | ID_W | Granted interrupt number |
| gnt_vec | output | VEC_W | Vector address of the grant |
| gnt_set_i | output | 1 | Core must set its general mask bit |
| gnt_set_x | output | 1 | Core must set its non-maskable mask bit |
| gnt_cost | output | COST_W | Service-entry cycle cost |
| raise_cnt | output | CNT_W | Count of directly raised requests |

## Verification
The arbitration is exercised with single flags with and without their enables, several requests raised together in one cycle, and each mask-bit combination. These tell apart the gating of each flag, the fixed order of the two traps, the blocking effect of a masked non-maskable request, and the hold-off made by the general mask. Sequences spread over several boundaries show that a held request is served once its mask opens, that a grant removes only its own bit, and that nothing moves without the strobe. A rewritten order table, and its return to identity order after reset, separate programmed rank from the plain numeric rank.

// File: rtl/irq_arb_pkg.sv
// Shared constants and types for the interrupt arbiter.
package irq_arb_pkg;
    localparam logic [15:0] VEC_BASE_DEF = 16'hFFC0;
    localparam int          SVC_COST     = 14;

    // Class of the winning request on a boundary
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SOFT = 2'd1,
        CLS_NMI  = 2'd2,
        CLS_MASK = 2'd3
    } irq_cls_e;
endpackage

// File: rtl/irq_pend.sv
// Pending-mask keeper. It folds gated peripheral flags and the direct
// raise mask into a sticky pending mask. It presents the candidate set
// (held plus newly set bits) and clears one granted bit per cycle.
// It assumes at most one clear per cycle and flag map entries below NUM_INT.
module irq_pend #(
    parameter int unsigned NUM_INT              = 16,
    parameter int unsigned FLAG_N               = 8,
    parameter int unsigned FLAG_MAP [FLAG_N]    = '{1, 1, 1, 1, 2, 3, 4, 5},
    parameter logic [FLAG_N-1:0] FLAG_HAS_EN    = 8'b1101_1111,
    parameter int unsigned CNT_W                = 16,
    localparam int unsigned ID_W                = $clog2(NUM_INT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLAG_N-1:0]  flag_in,
    input  logic [FLAG_N-1:0]  flag_en,
    input  logic [NUM_INT-1:0] sw_raise,
    input  logic               clr_vld,
    input  logic [ID_W-1:0]    clr_id,
    output logic [NUM_INT-1:0] cand,
    output logic [CNT_W-1:0]   raise_cnt
);
    logic [FLAG_N-1:0]  hit;
    logic [NUM_INT-1:0] set_now;
    logic [NUM_INT-1:0] pend_q;
    logic [NUM_INT-1:0] clr_mask;

    // Gate each flag with its enable when the flag owns one
    for (genvar g = 0; g < FLAG_N; g++) begin : g_gate
        assign hit[g] = flag_in[g] & (flag_en[g] | ~FLAG_HAS_EN[g]);
    end

    // Map gated flags onto interrupt numbers and merge direct raises
    always_comb begin
        set_now = sw_raise;
        for (int f = 0; f < FLAG_N; f++) begin
            if (hit[f]) set_now[ID_W'(FLAG_MAP[f])] = 1'b1;
        end
    end

    assign cand     = pend_q | set_now;
    assign clr_mask = clr_vld ? (NUM_INT'(1) << clr_id) : '0;

    // Hold pending requests and drop the one just granted
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= cand & ~clr_mask;
    end

    // Count every directly raised request
    always_ff @(posedge clk) begin
        if (!rst_n) raise_cnt <= '0;
        else        raise_cnt <= raise_cnt + CNT_W'($countones(sw_raise));
    end
endmodule

// File: rtl/irq_order.sv
// Programmable rank table for ordinary sources. Slot 0 ranks highest.
// It scans the slots and reports the first candidate found.
// It assumes ord_slot is below NUM_INT; duplicate entries are allowed.
module irq_order #(
    parameter int unsigned NUM_INT = 16,
    localparam int unsigned ID_W   = $clog2(NUM_INT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ord_we,
    input  logic [ID_W-1:0]    ord_slot,
    input  logic [ID_W-1:0]    ord_id,
    input  logic [NUM_INT-1:0] cand,
    output logic               mask_hit,
    output logic [ID_W-1:0]    mask_id
);
    logic [ID_W-1:0] ord_q [NUM_INT];

    // Load the identity order at reset, else apply table writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_INT; k++) ord_q[k] <= ID_W'(k);
        end else if (ord_we) begin
            ord_q[ord_slot] <= ord_id;
        end
    end

    // Walk slots from lowest rank up so the highest-ranked hit is kept
    always_comb begin
        mask_hit = 1'b0;
        mask_id  = '0;
        for (int s = NUM_INT - 1; s >= 0; s--) begin
            if (cand[ord_q[s]]) begin
                mask_hit = 1'b1;
                mask_id  = ord_q[s];
            end
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Class resolver and grant register. It applies the fixed order
// (software trap, illegal trap, non-maskable line, ordinary sources)
// against the two mask bits, and registers a one-cycle grant.
// It assumes the three special numbers are distinct.
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_INT        = 16,
    parameter int unsigned SWI_ID         = 13,
    parameter int unsigned ILL_ID         = 14,
    parameter int unsigned XIRQ_ID        = 15,
    parameter int unsigned VEC_W          = 16,
    parameter logic [VEC_W-1:0] VEC_BASE  = VEC_BASE_DEF,
    parameter int unsigned COST_W         = 8,
    localparam int unsigned ID_W          = $clog2(NUM_INT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_swi,
    input  logic              req_ill,
    input  logic              req_xirq,
    input  logic              mask_hit,
    input  logic [ID_W-1:0]   mask_id,
    input  logic              ccr_i,
    input  logic              ccr_x,
    input  logic              insn_done,
    output logic              win_vld,
    output logic [ID_W-1:0]   win_id,
    output logic              gnt_vld,
    output logic [ID_W-1:0]   gnt_id,
    output logic [VEC_W-1:0]  gnt_vec,
    output logic              gnt_set_i,
    output logic              gnt_set_x,
    output logic [COST_W-1:0] gnt_cost
);
    irq_cls_e cls;

    // Decide the winning class and number for this boundary
    always_comb begin
        cls    = CLS_NONE;
        win_id = '0;
        if (req_swi) begin
            cls    = CLS_SOFT;
            win_id = ID_W'(SWI_ID);
        end else if (req_ill) begin
            cls    = CLS_SOFT;
            win_id = ID_W'(ILL_ID);
        end else if (req_xirq) begin
            if (!ccr_x) begin
                cls    = CLS_NMI;
                win_id = ID_W'(XIRQ_ID);
            end
        end else if (!ccr_i && mask_hit) begin
            cls    = CLS_MASK;
            win_id = mask_id;
        end
    end

    assign win_vld = insn_done && (cls != CLS_NONE);

    // Register the grant for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !win_vld) begin
            gnt_vld   <= 1'b0;
            gnt_id    <= '0;
            gnt_vec   <= '0;
            gnt_set_i <= 1'b0;
            gnt_set_x <= 1'b0;
            gnt_cost  <= '0;
        end else begin
            gnt_vld   <= 1'b1;
            gnt_id    <= win_id;
            gnt_vec   <= VEC_BASE + (VEC_W'(win_id) << 1);
            gnt_set_i <= (cls != CLS_NMI);
            gnt_set_x <= (cls == CLS_NMI);
            gnt_cost  <= COST_W'(SVC_COST);
        end
    end
endmodule

// File: rtl/irq_vector_arb.sv
// Top of the interrupt arbiter: pending keeper, rank table and class
// resolver. A grant clears its own pending bit in the same cycle.
// It assumes the core applies gnt_set_i / gnt_set_x before the next
// boundary strobe.
module irq_vector_arb
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_INT              = 16,
    parameter int unsigned FLAG_N               = 8,
    parameter int unsigned FLAG_MAP [FLAG_N]    = '{1, 1, 1, 1, 2, 3, 4, 5},
    parameter logic [FLAG_N-1:0] FLAG_HAS_EN    = 8'b1101_1111,
    parameter int unsigned SWI_ID               = 13,
    parameter int unsigned ILL_ID               = 14,
    parameter int unsigned XIRQ_ID              = 15,
    parameter int unsigned VEC_W                = 16,
    parameter logic [VEC_W-1:0] VEC_BASE        = VEC_BASE_DEF,
    parameter int unsigned COST_W               = 8,
    parameter int unsigned CNT_W                = 16,
    localparam int unsigned ID_W                = $clog2(NUM_INT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLAG_N-1:0]  flag_in,
    input  logic [FLAG_N-1:0]  flag_en,
    input  logic [NUM_INT-1:0] sw_raise,
    input  logic               ccr_i,
    input  logic               ccr_x,
    input  logic               insn_done,
    input  logic               ord_we,
    input  logic [ID_W-1:0]    ord_slot,
    input  logic [ID_W-1:0]    ord_id,
    output logic               gnt_vld,
    output logic [ID_W-1:0]    gnt_id,
    output logic [VEC_W-1:0]   gnt_vec,
    output logic               gnt_set_i,
    output logic               gnt_set_x,
    output logic [COST_W-1:0]  gnt_cost,
    output logic [CNT_W-1:0]   raise_cnt
);
    logic [NUM_INT-1:0] cand;
    logic               mask_hit;
    logic [ID_W-1:0]    mask_id;
    logic               win_vld;
    logic [ID_W-1:0]    win_id;

    irq_pend #(
        .NUM_INT(NUM_INT), .FLAG_N(FLAG_N), .FLAG_MAP(FLAG_MAP),
        .FLAG_HAS_EN(FLAG_HAS_EN), .CNT_W(CNT_W)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .flag_en(flag_en),
        .sw_raise(sw_raise), .clr_vld(win_vld), .clr_id(win_id),
        .cand(cand), .raise_cnt(raise_cnt)
    );

    irq_order #(.NUM_INT(NUM_INT)) u_order (
        .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_slot(ord_slot),
        .ord_id(ord_id), .cand(cand), .mask_hit(mask_hit), .mask_id(mask_id)
    );

    irq_pick #(
        .NUM_INT(NUM_INT), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID),
        .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .COST_W(COST_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .req_swi(cand[SWI_ID]), .req_ill(cand[ILL_ID]), .req_xirq(cand[XIRQ_ID]),
        .mask_hit(mask_hit), .mask_id(mask_id), .ccr_i(ccr_i), .ccr_x(ccr_x),
        .insn_done(insn_done), .win_vld(win_vld), .win_id(win_id),
        .gnt_vld(gnt_vld), .gnt_id(gnt_id), .gnt_vec(gnt_vec),
        .gnt_set_i(gnt_set_i), .gnt_set_x(gnt_set_x), .gnt_cost(gnt_cost)
    );
endmodule

// File: rtl/irq_vector_arb_chk.sv
// Property checker for the interrupt arbiter, bound to its top.
// It observes top-level ports only.
module irq_vector_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_INT       = 16,
    parameter int unsigned SWI_ID        = 13,
    parameter int unsigned ILL_ID        = 14,
    parameter int unsigned XIRQ_ID       = 15,
    parameter int unsigned VEC_W         = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = VEC_BASE_DEF,
    parameter int unsigned COST_W        = 8,
    parameter int unsigned CNT_W         = 16,
    localparam int unsigned ID_W         = $clog2(NUM_INT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               insn_done,
    input logic               ccr_i,
    input logic               ccr_x,
    input logic [NUM_INT-1:0] sw_raise,
    input logic               gnt_vld,
    input logic [ID_W-1:0]    gnt_id,
    input logic [VEC_W-1:0]   gnt_vec,
    input logic               gnt_set_i,
    input logic               gnt_set_x,
    input logic [COST_W-1:0]  gnt_cost,
    input logic [CNT_W-1:0]   raise_cnt
);
    // R11
    grant_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> $past(insn_done));

    // R3
    nmi_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && gnt_id == ID_W'(XIRQ_ID)) |-> !$past(ccr_x));

    // R4
    ordinary_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && gnt_id != ID_W'(XIRQ_ID) && gnt_id != ID_W'(SWI_ID)
         && gnt_id != ID_W'(ILL_ID)) |-> !$past(ccr_i));

    // R6
    vector_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> gnt_vec == VEC_BASE + (VEC_W'(gnt_id) << 1));

    // R7
    one_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> $countones({gnt_set_i, gnt_set_x}) == 1);

    // R7
    idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |-> !gnt_set_i && !gnt_set_x);

    // R7
    nmi_sets_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (gnt_set_x == (gnt_id == ID_W'(XIRQ_ID))));

    // R8
    entry_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> gnt_cost == COST_W'(SVC_COST));

    // R10
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_raise == '0) |=> $stable(raise_cnt));
endmodule

bind irq_vector_arb irq_vector_arb_chk #(
    .NUM_INT(NUM_INT), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID),
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .COST_W(COST_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .ccr_i(ccr_i),
    .ccr_x(ccr_x), .sw_raise(sw_raise), .gnt_vld(gnt_vld), .gnt_id(gnt_id),
    .gnt_vec(gnt_vec), .gnt_set_i(gnt_set_i), .gnt_set_x(gnt_set_x),
    .gnt_cost(gnt_cost), .raise_cnt(raise_cnt)
);

// File: tb/tb_irq_vector_arb.sv
module tb_irq_vector_arb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic        i;
        logic        x;
        logic [7:0]  fl;
        logic [7:0]  en;
        logic [15:0] rs;
        logic        ev;
        logic [3:0]  eid;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'h01, 8'h01, 16'h0000, 1'b1, 4'd1},   // R1 gated flag
        '{1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 1'b0, 4'd0},   // R1 enable low
        '{1'b0, 1'b0, 8'h20, 8'h00, 16'h0000, 1'b1, 4'd3},   // R1 no-enable flag
        '{1'b1, 1'b1, 8'h00, 8'h00, 16'h6000, 1'b1, 4'd13},  // R2 soft trap first
        '{1'b1, 1'b1, 8'h00, 8'h00, 16'hC000, 1'b1, 4'd14},  // R2 illegal over nmi
        '{1'b1, 1'b0, 8'h80, 8'h80, 16'h8000, 1'b1, 4'd15},  // R3 nmi open
        '{1'b0, 1'b1, 8'h01, 8'h01, 16'h8000, 1'b0, 4'd0},   // R3 masked nmi blocks
        '{1'b1, 1'b0, 8'h10, 8'h10, 16'h0000, 1'b0, 4'd0},   // R4 general mask
        '{1'b0, 1'b0, 8'h90, 8'h90, 16'h0000, 1'b1, 4'd2},   // R5 lowest wins
        '{1'b0, 1'b0, 8'h40, 8'h40, 16'h0080, 1'b1, 4'd4}    // R5 lowest wins
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  flag_in;
    logic [7:0]  flag_en;
    logic [15:0] sw_raise;
    logic        ccr_i;
    logic        ccr_x;
    logic        insn_done;
    logic        ord_we;
    logic [3:0]  ord_slot;
    logic [3:0]  ord_id;
    logic        gnt_vld;
    logic [3:0]  gnt_id;
    logic [15:0] gnt_vec;
    logic        gnt_set_i;
    logic        gnt_set_x;
    logic [7:0]  gnt_cost;
    logic [15:0] raise_cnt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    string vreq [NVEC] = '{"R1", "R1", "R1", "R2", "R2", "R3", "R3", "R4", "R5", "R5"};

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_arb dut (
        .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .flag_en(flag_en),
        .sw_raise(sw_raise), .ccr_i(ccr_i), .ccr_x(ccr_x),
        .insn_done(insn_done), .ord_we(ord_we), .ord_slot(ord_slot),
        .ord_id(ord_id), .gnt_vld(gnt_vld), .gnt_id(gnt_id),
        .gnt_vec(gnt_vec), .gnt_set_i(gnt_set_i), .gnt_set_x(gnt_set_x),
        .gnt_cost(gnt_cost), .raise_cnt(raise_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flag_in = '0; flag_en = '0; sw_raise = '0; ccr_i = 1'b0; ccr_x = 1'b0;
        insn_done = 1'b0; ord_we = 1'b0; ord_slot = '0; ord_id = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
    endtask

    // Check the full grant bundle against an expected number (or none)
    task automatic chk_grant(input string req, input logic ev, input logic [3:0] eid);
        chk(req, 32'(gnt_vld), 32'(ev));
        if (ev) begin
            chk(req, 32'(gnt_id), 32'(eid));
            chk({req, "/R6"}, 32'(gnt_vec), 32'(16'hFFC0 + 16'(eid) * 2));
            chk({req, "/R7"}, 32'({gnt_set_i, gnt_set_x}), (eid == 4'd15) ? 32'd1 : 32'd2);
            chk({req, "/R8"}, 32'(gnt_cost), 32'd14);
        end else begin
            chk({req, "/R7"}, 32'({gnt_set_i, gnt_set_x}), 32'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        tick();
        tick();
        rst_n = 1'b1;

        // R10 R11 reset state
        chk("R11 reset", 32'(gnt_vld), 32'd0);
        chk("R10 reset", 32'(raise_cnt), 32'd0);

        // Vector table, one boundary per entry from a clean reset
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            ccr_i = VECS[v].i; ccr_x = VECS[v].x;
            flag_in = VECS[v].fl; flag_en = VECS[v].en;
            sw_raise = VECS[v].rs; insn_done = 1'b1;
            tick();
            idle_inputs();
            chk_grant(vreq[v], VECS[v].ev, VECS[v].eid);
        end

        // R9 grant clears only its own bit
        do_reset();
        sw_raise = 16'h00C0; insn_done = 1'b1;
        tick(); sw_raise = '0;
        chk_grant("R9 first", 1'b1, 4'd6);
        tick();
        chk_grant("R9 second", 1'b1, 4'd7);
        tick();
        chk_grant("R9 drained", 1'b0, 4'd0);

        // R9 reset empties the pending mask
        do_reset();
        sw_raise = 16'h0100;
        tick();
        do_reset();
        insn_done = 1'b1;
        tick();
        chk_grant("R9 reset clears", 1'b0, 4'd0);

        // R11 no arbitration without the strobe, one-cycle grant
        do_reset();
        sw_raise = 16'h0200;
        tick(); sw_raise = '0;
        chk("R11 no strobe", 32'(gnt_vld), 32'd0);
        tick();
        chk("R11 no strobe 2", 32'(gnt_vld), 32'd0);
        insn_done = 1'b1;
        tick(); insn_done = 1'b0;
        chk_grant("R11 strobe", 1'b1, 4'd9);
        tick();
        chk("R11 one cycle", 32'(gnt_vld), 32'd0);

        // R1 pending stays after a short flag pulse
        do_reset();
        flag_in = 8'h40; flag_en = 8'h40;
        tick(); flag_in = '0; flag_en = '0;
        insn_done = 1'b1;
        tick();
        chk_grant("R1 sticky", 1'b1, 4'd4);

        // R5 rewritten order, then reset restores identity
        do_reset();
        ord_we = 1'b1; ord_slot = 4'd0; ord_id = 4'd9;
        tick(); ord_we = 1'b0;
        sw_raise = 16'h0204; insn_done = 1'b1;
        tick();
        chk_grant("R5 table write", 1'b1, 4'd9);
        do_reset();
        sw_raise = 16'h0204; insn_done = 1'b1;
        tick();
        chk_grant("R5 identity after reset", 1'b1, 4'd2);

        // R4 held-off source served once the mask opens
        do_reset();
        sw_raise = 16'h0080; ccr_i = 1'b1; insn_done = 1'b1;
        tick(); sw_raise = '0;
        chk_grant("R4 held", 1'b0, 4'd0);
        ccr_i = 1'b0;
        tick();
        chk_grant("R4 released", 1'b1, 4'd7);

        // R3 masked nmi served later
        do_reset();
        sw_raise = 16'h8000; ccr_x = 1'b1; insn_done = 1'b1;
        tick(); sw_raise = '0;
        chk_grant("R3 held", 1'b0, 4'd0);
        ccr_x = 1'b0;
        tick();
        chk_grant("R3 released", 1'b1, 4'd15);

        // R10 counter adds raised bits per cycle
        do_reset();
        sw_raise = 16'h0011;
        tick();
        sw_raise = 16'h0400;
        tick();
        sw_raise = '0;
        tick();
        chk("R10 count", 32'(raise_cnt), 32'd3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule